// File: doc/BRIEF.md
# Combined-Frame Converter Host Controller

This block is the master side of a serial link to a sampling converter. The converter's read and write frame-sync pins are wired together, so a single active-low sync line frames both directions at once. During one frame of sixteen serial clocks the controller sends a five-bit control word (channel select, convert command, standby bit) and receives the converter's sixteen-bit result frame.

A user pulses `start` with a channel number and a convert flag. The controller then drops the sync line and generates sixteen serial clock pulses. The clock idles low, the controller changes outgoing data on the rising edge, and both sides sample on the falling edge. When the frame is over, the controller returns sync high and pulses `done` for one system clock. With that pulse it presents the received channel address, the 12-bit result and a flag that reports a nonzero leading bit. The serial clock half period is `HALF_DIV` system clocks.

Top module: `adc_frame_host`

## Requirements
- R1: After reset `sync_n` is 1, and `sclk`, `ctl_sdo`, `busy`, `done`, `addr`, `result` and `lead_err` are all 0.
- R2: A `start` sampled high while `busy` is 0 is accepted at that clock edge, and `busy` is 1 and `sync_n` is 0 from that edge on.
- R3: Each frame has exactly 16 `sclk` pulses, and `sclk` is low whenever `sync_n` is high. The first rising edge comes `HALF_DIV` system clocks after `sync_n` falls, and each half period lasts `HALF_DIV` system clocks, so the sixteenth falling edge comes 31*`HALF_DIV` clocks after the first rising edge.
- R4: `sync_n` rises `HALF_DIV` clocks after the sixteenth falling edge, which is 33*`HALF_DIV` clocks after it fell. `done` is high for exactly that one clock, and `busy` drops at the same edge.
- R5: `ctl_sdo` changes only on rising `sclk` edges. At falling edges 1 to 5 it carries chan[2], chan[1], chan[0], conv, then 0 for the standby bit. At falling edges 6 to 16 it carries 0.
- R6: `res_sdi` is sampled at each falling `sclk` edge. Bit 1 is the leading bit, bits 2 to 4 are the address with its MSB first, and bits 5 to 16 are the result with its MSB first. The address appears on `addr` and the result on `result`, both updated with `done`.
- R7: `lead_err` equals the leading bit received in the last frame, so it is 1 when that bit was nonzero.
- R8: A `start` that arrives while `busy` is 1 is ignored. It starts no extra frame and does not change the control word being sent.
- R9: `addr`, `result` and `lead_err` hold their values between `done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to run one frame |
| chan | input | 3 | Channel to select |
| conv | input | 1 | Convert command bit |
| res_sdi | input | 1 | Serial result data from the converter |
| sclk | output | 1 | Serial clock, idle low |
| sync_n | output | 1 | Shared active-low frame sync |
| ctl_sdo | output | 1 | Serial control data to the converter |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-clock frame-complete strobe |
| addr | output | 3 | Received channel address |
| result | output | 12 | Received 12-bit result |
| lead_err | output | 1 | Received leading bit was nonzero |

## Verification
The bench numbers every cycle by sampling just after each rising clock edge. It then checks each event at its exact distance from the accept edge. `busy` and the sync fall are due one cycle after the start request is sampled. The first serial clock rise is due `HALF_DIV` cycles after the sync fall, the sixteenth fall 31*`HALF_DIV` cycles after that, and the sync rise together with `done` a further `HALF_DIV` cycles later. A converter model in the bench drives result bits on rising serial clock edges and captures the control bits on falling edges. The bench sweeps every channel with both convert values, and compares the word each side received with the word the bench computed for that frame.

// File: rtl/adc_frame_host.sv
module adc_frame_host #(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  chan,
  input  logic        conv,
  input  logic        res_sdi,
  output logic        sclk,
  output logic        sync_n,
  output logic        ctl_sdo,
  output logic        busy,
  output logic        done,
  output logic [2:0]  addr,
  output logic [11:0] result,
  output logic        lead_err
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int LAST_HALF = 32;

  logic [CW-1:0] hcnt;
  logic [5:0]    half;
  logic [15:0]   tx, rx;

  wire tick = busy && (hcnt == CW'(HALF_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk     <= 1'b0;
      sync_n   <= 1'b1;
      ctl_sdo  <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      addr     <= '0;
      result   <= '0;
      lead_err <= 1'b0;
      hcnt     <= '0;
      half     <= '0;
      tx       <= '0;
      rx       <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          sync_n <= 1'b0;
          hcnt   <= '0;
          half   <= '0;
          tx     <= {chan, conv, 1'b0, 11'b0};
        end
      end else if (!tick) begin
        hcnt <= hcnt + 1'b1;
      end else begin
        hcnt <= '0;
        if (half == 6'(LAST_HALF)) begin
          busy     <= 1'b0;
          sync_n   <= 1'b1;
          done     <= 1'b1;
          ctl_sdo  <= 1'b0;
          addr     <= rx[14:12];
          result   <= rx[11:0];
          lead_err <= rx[15];
        end else begin
          half <= half + 1'b1;
          if (!half[0]) begin
            sclk    <= 1'b1;
            ctl_sdo <= tx[15];
            tx      <= {tx[14:0], 1'b0};
          end else begin
            sclk <= 1'b0;
            rx   <= {rx[14:0], res_sdi};
          end
        end
      end
    end
  end
endmodule

// File: rtl/adc_frame_host_chk.sv
module adc_frame_host_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        sclk,
  input logic        sync_n,
  input logic        ctl_sdo,
  input logic        busy,
  input logic        done,
  input logic [2:0]  addr,
  input logic [11:0] result,
  input logic        lead_err
);
  assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && !sync_n);

  assert_sclk_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sync_n |-> !sclk);

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_closes_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> sync_n && !busy && !$past(sync_n));

  assert_sdo_steady_at_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> $stable(ctl_sdo));

  assert_outputs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(addr) && $stable(result) && $stable(lead_err));
endmodule

bind adc_frame_host adc_frame_host_chk u_chk (.*);

// File: tb/adc_frame_host_test.sv
`timescale 1ns/1ps
module adc_frame_host_test;
  localparam int D = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, conv = 1'b0, res_sdi = 1'b0;
  logic [2:0] chan = '0;
  logic sclk, sync_n, ctl_sdo, busy, done, lead_err;
  logic [2:0] addr;
  logic [11:0] result;

  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  adc_frame_host #(.HALF_DIV(D)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .chan(chan), .conv(conv),
    .res_sdi(res_sdi), .sclk(sclk), .sync_n(sync_n), .ctl_sdo(ctl_sdo),
    .busy(busy), .done(done), .addr(addr), .result(result), .lead_err(lead_err));

  // converter model
  logic [15:0] sl_frame = '0, sl_rx = '0;
  int sl_k = 0;
  always @(negedge sync_n) begin sl_k = 0; sl_rx = '0; end
  always @(posedge sclk) begin
    res_sdi = sl_frame[4'(15 - sl_k)];
    sl_k++;
  end
  always @(negedge sclk) sl_rx = {sl_rx[14:0], ctl_sdo};

  // cycle monitor
  int cyc = 0, rc = 0, fc = 0, nfr = 0, dcount = 0;
  int t_fs_fall = 0, t_first_rise = 0, t_last_fall = 0, t_fs_rise = 0, t_done = 0;
  logic p_sclk = 1'b0, p_fs = 1'b1;
  always @(posedge clk) begin
    #1;
    cyc++;
    if (p_fs && !sync_n) begin t_fs_fall = cyc; rc = 0; fc = 0; nfr++; end
    if (!p_sclk && sclk) begin rc++; if (rc == 1) t_first_rise = cyc; end
    if (p_sclk && !sclk) begin fc++; t_last_fall = cyc; end
    if (!p_fs && sync_n) t_fs_rise = cyc;
    if (done) begin t_done = cyc; dcount++; end
    p_sclk = sclk;
    p_fs = sync_n;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [2:0] ch, input logic cv, input logic ld,
                           input logic [2:0] sa, input logic [11:0] res, input bit poke);
    int d0, n0;
    d0 = dcount;
    n0 = nfr;
    sl_frame = {ld, sa, res};
    @(negedge clk); chan = ch; conv = cv; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && !sync_n, "R2 accept", {30'd0, busy, sync_n}, 2);
    if (poke) begin
      repeat (10) @(negedge clk);
      chan = ~ch; conv = ~cv; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    wait (dcount != d0);
    repeat (3) @(negedge clk);
    chk(rc == 16, "R3 rising edges", rc, 16);
    chk(fc == 16, "R3 falling edges", fc, 16);
    chk(t_first_rise - t_fs_fall == D, "R3 first rise delay", t_first_rise - t_fs_fall, D);
    chk(t_last_fall - t_first_rise == 31 * D, "R3 pulse train span", t_last_fall - t_first_rise, 31 * D);
    chk(t_fs_rise - t_last_fall == D, "R4 sync rise delay", t_fs_rise - t_last_fall, D);
    chk(t_done == t_fs_rise, "R4 done with sync rise", t_done, t_fs_rise);
    chk(t_done - t_fs_fall == 33 * D, "R4 frame length", t_done - t_fs_fall, 33 * D);
    chk(dcount - d0 == 1, "R4 single done", dcount - d0, 1);
    chk(sl_rx == {ch, cv, 1'b0, 11'b0}, "R5 control word", int'(sl_rx), int'({ch, cv, 1'b0, 11'b0}));
    chk(addr == sa, "R6 address", int'(addr), int'(sa));
    chk(result == res, "R6 result", int'(result), int'(res));
    chk(lead_err == ld, "R7 leading flag", int'(lead_err), int'(ld));
    if (poke) begin
      chk(nfr - n0 == 1, "R8 no extra frame", nfr - n0, 1);
      chk(!busy && sync_n, "R8 idle after frame", {30'd0, busy, sync_n}, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sync_n && !sclk && !ctl_sdo && !busy && !done, "R1 reset controls",
        {27'd0, sync_n, sclk, ctl_sdo, busy, done}, 16);
    chk(addr == 0 && result == 0 && !lead_err, "R1 reset data", int'(result), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(sync_n && !busy, "R1 idle after reset", {30'd0, sync_n, busy}, 2);

    for (int ch = 0; ch < 8; ch++)
      for (int cv = 0; cv < 2; cv++)
        run_frame(3'(ch), 1'(cv), 1'b0, 3'(ch) ^ 3'b101,
                  12'((ch * 517 + cv * 1234 + 77) & 12'hFFF), 1'b0);

    run_frame(3'd6, 1'b1, 1'b1, 3'd7, 12'hFFF, 1'b0);
    run_frame(3'd1, 1'b0, 1'b0, 3'd0, 12'h000, 1'b0);
    run_frame(3'd5, 1'b1, 1'b0, 3'd2, 12'hA5C, 1'b1);

    repeat (20) @(negedge clk);
    chk(addr == 3'd2 && result == 12'hA5C && !lead_err, "R9 outputs hold", int'(result), 'hA5C);
    chk(sync_n && !sclk && !busy, "R3 idle between frames", {29'd0, sync_n, sclk, busy}, 4);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule